// File: doc/BRIEF.md
# Per-Thread Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken, for a core that runs up to four hardware threads at once. All threads share one table of two-bit saturating counters. Each thread keeps its own global history register, so one program's branch outcomes never disturb the history of another. The table index is formed by XOR-ing low bits of the branch address with the requesting thread's history. An optional static mode reserves a quarter of the table for each thread by putting the thread id in the top index bits.

At predict time the block returns the direction, the index it used and a checkpoint, which is the thread's history before this prediction. It then shifts the predicted direction into that thread's history at once, without waiting for the branch to resolve. When a branch later turns out to be mispredicted, the caller hands back the checkpoint and the real outcome, and the history is rebuilt from them. Counter training is a separate port. It takes the index saved at predict time, so training never depends on how the history has moved since. The default table holds 1K counters. Raising the index width to 15 gives the full 32K-counter (64 Kbit) array.

Top module: `bp_xor_predictor`

## Requirements
- R1: In shared mode, `pred_index` equals `pred_pc[PC_LSB +: IDX_W]` XOR the requesting thread's history, zero-extended to IDX_W bits.
- R2: Each thread has its own history register. A prediction or a restore for one thread leaves every other thread's history unchanged.
- R3: `pred_taken` is bit 1 of the counter at `pred_index`, and `pred_ckpt` is the requesting thread's history as it stands before this prediction. Both outputs are combinational in the same cycle.
- R4: A cycle with `pred_valid` high shifts the thread's history left by one at the next clock edge, with `pred_taken` entering at bit 0.
- R5: A cycle with `res_valid` and `res_mispred` high sets thread `res_tid`'s history to `{res_ckpt[HIST_W-2:0], res_taken}`. A resolve with `res_mispred` low changes nothing.
- R6: When a prediction and a mispredict restore target the same thread in the same cycle, the restore value is the one that is kept.
- R7: `upd_valid` moves the counter at `upd_index` up by one when `upd_taken` is high and down by one when it is low. The count saturates at 3 and at 0.
- R8: When an update and a prediction touch the same index in the same cycle, the prediction sees the counter value from before the update. The updated value is visible from the next cycle.
- R9: With `SPLIT_TABLE`=1, `pred_index` is `{pred_tid, low IDX_W-2 bits of the R1 XOR}`.
- R10: After reset, every history is zero and every counter holds 1 (weakly not-taken), so every prediction reads not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction request |
| pred_pc | input | PC_W | Branch address |
| pred_tid | input | TID_W | Requesting thread |
| pred_taken | output | 1 | Predicted direction |
| pred_ckpt | output | HIST_W | Thread history before this prediction |
| pred_index | output | IDX_W | Table index used |
| res_valid | input | 1 | Branch resolution |
| res_tid | input | TID_W | Resolving thread |
| res_taken | input | 1 | Actual outcome |
| res_mispred | input | 1 | Prediction was wrong |
| res_ckpt | input | HIST_W | Checkpoint returned from predict time |
| upd_valid | input | 1 | Counter training request |
| upd_index | input | IDX_W | Index saved at predict time |
| upd_taken | input | 1 | Actual outcome for training |

## Verification
Two pairs of operations can land in the same cycle. A speculative shift and a mispredict restore can hit the same thread (R6), and a counter update and a table read can hit the same entry (R8). The bench forces both pairs in directed steps: it aims a resolve at the thread being predicted, and it picks a PC whose XOR with the model's current history lands on the entry being trained. Random traffic provokes both pairs again. The outcome is judged on the next cycle's checkpoint and direction, compared against a behavioural model that applies the restore after the shift and reads the table before training it.

// File: rtl/bp_types_pkg.sv
package bp_types_pkg;

  localparam logic [1:0] CTR_STRONG_NT = 2'd0;
  localparam logic [1:0] CTR_WEAK_NT   = 2'd1;
  localparam logic [1:0] CTR_WEAK_T    = 2'd2;
  localparam logic [1:0] CTR_STRONG_T  = 2'd3;

  // saturating step of a two-bit direction counter
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    if (taken) return (c == CTR_STRONG_T)  ? c : c + 2'd1;
    else       return (c == CTR_STRONG_NT) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/bp_hist_bank.sv
module bp_hist_bank #(
  parameter int NUM_THR = 4,
  parameter int HIST_W  = 10,
  localparam int TID_W  = $clog2(NUM_THR)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spec_en,
  input  logic [TID_W-1:0]           spec_tid,
  input  logic                       spec_bit,
  input  logic                       fix_en,
  input  logic [TID_W-1:0]           fix_tid,
  input  logic [HIST_W-1:0]          fix_ckpt,
  input  logic                       fix_bit,
  input  logic [TID_W-1:0]           rd_tid,
  output logic [HIST_W-1:0]          rd_hist,
  output logic [NUM_THR*HIST_W-1:0]  hist_flat
);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic [HIST_W-1:0] h_q;
    logic              fix_hit, spec_hit;
    assign fix_hit  = fix_en  && (fix_tid  == TID_W'(t));
    assign spec_hit = spec_en && (spec_tid == TID_W'(t));

    // restore has priority over the speculative shift (R6)
    always_ff @(posedge clk) begin
      if (!rst_n)        h_q <= '0;
      else if (fix_hit)  h_q <= {fix_ckpt[HIST_W-2:0], fix_bit};
      else if (spec_hit) h_q <= {h_q[HIST_W-2:0], spec_bit};
    end
    assign hist_flat[t*HIST_W +: HIST_W] = h_q;
  end

  assign rd_hist = hist_flat[rd_tid*HIST_W +: HIST_W];

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_types_pkg::*;
#(
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic [1:0]       wr_old,
  output logic [1:0]       wr_new
);

  logic [1:0] tbl [DEPTH];

  assign rd_ctr = tbl[rd_idx];
  assign wr_old = tbl[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_new;
    end
  end

endmodule

// File: rtl/bp_xor_predictor.sv
module bp_xor_predictor #(
  parameter int NUM_THR     = 4,
  parameter int PC_W        = 32,
  parameter int PC_LSB      = 2,
  parameter int IDX_W       = 10,
  parameter int HIST_W      = 10,
  parameter bit SPLIT_TABLE = 1'b0,
  localparam int TID_W      = $clog2(NUM_THR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [PC_W-1:0]   pred_pc,
  input  logic [TID_W-1:0]  pred_tid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_ckpt,
  output logic [IDX_W-1:0]  pred_index,
  input  logic              res_valid,
  input  logic [TID_W-1:0]  res_tid,
  input  logic              res_taken,
  input  logic              res_mispred,
  input  logic [HIST_W-1:0] res_ckpt,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_index,
  input  logic              upd_taken
);

  // index hash: address bits XOR zero-extended history, optional thread field on top
  function automatic logic [IDX_W-1:0] form_index(input logic [PC_W-1:0] pc,
                                                  input logic [HIST_W-1:0] h,
                                                  input logic [TID_W-1:0] tid);
    logic [IDX_W-1:0] hx, mix;
    hx = '0;
    hx[HIST_W-1:0] = h;
    mix = pc[PC_LSB +: IDX_W] ^ hx;
    if (SPLIT_TABLE) mix[IDX_W-1 -: TID_W] = tid;
    return mix;
  endfunction

  // named internal events for the checker
  logic                      restore_ev;
  logic                      shift_ev;
  logic [NUM_THR*HIST_W-1:0] hist_flat;
  logic [1:0]                rd_ctr, wr_old, wr_new;

  assign restore_ev = res_valid && res_mispred;
  assign shift_ev   = pred_valid;

  bp_hist_bank #(.NUM_THR(NUM_THR), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .spec_en(shift_ev), .spec_tid(pred_tid), .spec_bit(pred_taken),
    .fix_en(restore_ev), .fix_tid(res_tid), .fix_ckpt(res_ckpt), .fix_bit(res_taken),
    .rd_tid(pred_tid), .rd_hist(pred_ckpt), .hist_flat(hist_flat)
  );

  assign pred_index = form_index(pred_pc, pred_ckpt, pred_tid);

  bp_ctr_table #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_index), .rd_ctr(rd_ctr),
    .wr_en(upd_valid), .wr_idx(upd_index), .wr_taken(upd_taken),
    .wr_old(wr_old), .wr_new(wr_new)
  );

  assign pred_taken = rd_ctr[1];

endmodule

// File: rtl/bp_xor_predictor_chk.sv
module bp_xor_predictor_chk #(
  parameter int NUM_THR     = 4,
  parameter int IDX_W       = 10,
  parameter int HIST_W      = 10,
  parameter bit SPLIT_TABLE = 1'b0,
  localparam int TID_W      = $clog2(NUM_THR)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      shift_ev,
  input logic                      restore_ev,
  input logic [TID_W-1:0]          pred_tid,
  input logic                      pred_taken,
  input logic [HIST_W-1:0]         pred_ckpt,
  input logic [IDX_W-1:0]          pred_index,
  input logic [TID_W-1:0]          res_tid,
  input logic                      res_taken,
  input logic [HIST_W-1:0]         res_ckpt,
  input logic                      upd_valid,
  input logic                      upd_taken,
  input logic [1:0]                wr_old,
  input logic [1:0]                wr_new,
  input logic [NUM_THR*HIST_W-1:0] hist_flat
);

  p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_ev |=> hist_flat[$past(res_tid)*HIST_W +: HIST_W] ==
                   {$past(res_ckpt[HIST_W-2:0]), $past(res_taken)});

  p_spec_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !(restore_ev && res_tid == pred_tid)) |=>
      hist_flat[$past(pred_tid)*HIST_W +: HIST_W] ==
      {$past(pred_ckpt[HIST_W-2:0]), $past(pred_taken)});

  p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && wr_old == 2'd3) |-> wr_new == 2'd3);

  p_sat_bottom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && wr_old == 2'd0) |-> wr_new == 2'd0);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_iso
    p_hist_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(shift_ev && pred_tid == TID_W'(t)) && !(restore_ev && res_tid == TID_W'(t)))
        |=> $stable(hist_flat[t*HIST_W +: HIST_W]));
  end

  if (SPLIT_TABLE) begin : g_split
    p_split_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
      shift_ev |-> pred_index[IDX_W-1 -: TID_W] == pred_tid);
  end

endmodule

bind bp_xor_predictor bp_xor_predictor_chk #(
  .NUM_THR(NUM_THR), .IDX_W(IDX_W), .HIST_W(HIST_W), .SPLIT_TABLE(SPLIT_TABLE)
) u_chk (.*);

// File: tb/sim_bp_xor_predictor.sv
module sim_bp_xor_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR  = 4;
  localparam int IDXW  = 10;
  localparam int HISTW = 10;
  localparam int DEPTH = 1 << IDXW;
  localparam int IMASK = DEPTH - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pred_valid = 0, res_valid = 0, res_taken = 0, res_mispred = 0;
  logic upd_valid = 0, upd_taken = 0;
  logic [31:0] pred_pc = '0;
  logic [1:0] pred_tid = '0, res_tid = '0;
  logic [HISTW-1:0] res_ckpt = '0;
  logic [IDXW-1:0] upd_index = '0;
  logic pred_taken, s_taken;
  logic [HISTW-1:0] pred_ckpt, s_ckpt;
  logic [IDXW-1:0] pred_index, s_index;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_xor_predictor u0 (.*);

  bp_xor_predictor #(.SPLIT_TABLE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_tid(pred_tid),
    .pred_taken(s_taken), .pred_ckpt(s_ckpt), .pred_index(s_index),
    .res_valid(res_valid), .res_tid(res_tid), .res_taken(res_taken), .res_mispred(res_mispred),
    .res_ckpt(res_ckpt), .upd_valid(upd_valid), .upd_index(upd_index), .upd_taken(upd_taken));

  // behavioural reference state
  int m_hist [NTHR];
  int m_ctr  [DEPTH];
  int last_ckpt [NTHR];
  int last_idx  [NTHR];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, advance the model
  task automatic step(string tag, bit pv, int pc, int tid,
                      bit rv, int rt, bit rtk, bit rm, int rck,
                      bit uv, int ui, bit utk);
    int e_idx, e_tk, e_ck, ns;
    pred_valid = pv; pred_pc = pc; pred_tid = tid[1:0];
    res_valid = rv; res_tid = rt[1:0]; res_taken = rtk; res_mispred = rm; res_ckpt = rck[HISTW-1:0];
    upd_valid = uv; upd_index = ui[IDXW-1:0]; upd_taken = utk;
    #1;
    e_ck  = m_hist[tid];
    e_idx = ((pc >> 2) & IMASK) ^ e_ck;
    e_tk  = (m_ctr[e_idx] >> 1) & 1;
    chk({tag, " R1 index"}, int'(pred_index), e_idx);
    chk({tag, " R3 direction"}, int'(pred_taken), e_tk);
    chk({tag, " R4 checkpoint"}, int'(pred_ckpt), e_ck);
    // R9: split instance puts the thread id on top of the low hash bits
    chk({tag, " R9 split index"}, int'(s_index),
        (tid << (IDXW-2)) | ((((pc >> 2) & IMASK) ^ int'(s_ckpt)) & ((1 << (IDXW-2)) - 1)));
    if (pv) begin
      last_ckpt[tid] = e_ck;
      last_idx[tid]  = e_idx;
      m_hist[tid] = ((e_ck << 1) | e_tk) & IMASK;
    end
    if (rv && rm) m_hist[rt] = ((rck << 1) | rtk) & ((1 << HISTW) - 1);
    if (uv) begin
      ns = m_ctr[ui] + (utk ? 1 : -1);
      m_ctr[ui] = (ns > 3) ? 3 : (ns < 0) ? 0 : ns;
    end
    @(negedge clk);
  endtask

  function automatic int pc_for(int idx, int tid);
    return ((idx ^ m_hist[tid]) & IMASK) << 2;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NTHR; t++) begin m_hist[t] = 0; last_ckpt[t] = 0; last_idx[t] = 0; end
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state seen through predictions with pred_valid low
    for (int t = 0; t < NTHR; t++)
      step("R10 reset", 0, 32'h40 * (t + 1), t, 0, 0, 0, 0, 0, 0, 0, 0);

    // R7: saturate up then down at entry 37
    for (int k = 0; k < 5; k++) step("R7 train up", 0, 0, 0, 0, 0, 0, 0, 0, 1, 37, 1);
    step("R7 top", 0, pc_for(37, 2), 2, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step("R7 train down", 0, 0, 0, 0, 0, 0, 0, 0, 1, 37, 0);
    step("R7 bottom", 0, pc_for(37, 2), 2, 0, 0, 0, 0, 0, 0, 0, 0);

    // R4 and R2: shifts on thread 0 only, other threads observed after
    for (int k = 0; k < 6; k++) step("R4 shift", 1, 32'h100 + 4*k, 0, 0, 0, 0, 0, 0, 1, k, 1);
    for (int t = 1; t < NTHR; t++) step("R2 isolation", 0, 32'h80, t, 0, 0, 0, 0, 0, 0, 0, 0);

    // R5: restore, and a resolve without mispredict that must change nothing
    step("R5 restore", 0, 0, 0, 1, 0, 1, 1, 10'h2A5, 0, 0, 0);
    step("R5 no mispred", 0, 0, 0, 1, 0, 0, 0, 10'h111, 0, 0, 0);
    step("R5 check", 0, 32'h10, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R6: predict and restore the same thread in one cycle
    step("R6 collide", 1, 32'h330, 1, 1, 1, 0, 1, 10'h0F0, 0, 0, 0);
    step("R6 check", 0, 32'h330, 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R8: update and read the same entry in one cycle
    for (int k = 0; k < 3; k++) step("R8 same entry", 1, pc_for(200, 3), 3, 0, 0, 0, 0, 0, 1, 200, 1);
    step("R8 after", 0, pc_for(200, 3), 3, 0, 0, 0, 0, 0, 0, 0, 0);

    // random traffic, with collisions occurring naturally
    for (int n = 0; n < 4000; n++) begin
      int tid, rt, ut;
      tid = $urandom_range(0, 3);
      rt  = ($urandom_range(0, 3) == 0) ? tid : $urandom_range(0, 3);
      ut  = $urandom_range(0, 3);
      step("R2 R5 R6 R8 random",
           $urandom_range(0, 9) < 7, ($urandom_range(0, 63) << 2) | 32'h1000, tid,
           $urandom_range(0, 2) == 0, rt, $urandom_range(0, 1), $urandom_range(0, 1), last_ckpt[rt],
           $urandom_range(0, 1), last_idx[ut], $urandom_range(0, 3) != 0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule